// File: doc/BRIEF.md
# I2C Serial Clock Generator

This block derives the I2C serial clock from the module clock in two stages. A programmable prescaler divides the module clock by `prescale + 1` and produces one tick per division. A phase sequencer then counts these ticks. It holds SCL low for one programmed span and releases it high for another. Each span is lengthened by a fixed extra delay, and the size of that delay depends on the prescaler setting: 7 ticks when the prescaler is 0, 6 when it is 1, and 5 for any larger value.

A protocol engine next to this block sets `enable` to run the generator and holds `start` to ask for clock periods. It uses two one-cycle strobes. The first marks where SDA may change, which is the first cycle of each low phase. The second marks where SDA should be sampled, which is the middle of each high phase. The three divider inputs are copied into shadow registers only at a period boundary. A period that has begun therefore always runs to its end with the values it started with. Pulling `enable` low (or asserting `rst`) drops everything at once: SCL is released high and all counters clear.

Top module: `scl_clock_gen`

## Requirements
- R1: While `rst` is high or `enable` is low at a clock edge, the generator goes idle after that edge: `scl_out` = 1 (released), `sample_stb` = 0, `change_stb` = 0, and it stays that way for as long as the condition holds, whatever `start` does.
- R2: Every low phase of `scl_out` lasts exactly (`low_count` + d) × (`prescale` + 1) module clock cycles, using the values captured at the start of that period.
- R3: Every high phase of `scl_out` that is followed by another period lasts exactly (`high_count` + d) × (`prescale` + 1) module clock cycles.
- R4: The extra delay d is 7 when the captured prescale is 0, 6 when it is 1, and 5 when it is 2 or more.
- R5: `change_stb` is high for exactly one cycle, and that cycle is the first cycle of each low phase. It is never high at any other time.
- R6: `sample_stb` is high for exactly one cycle in each high phase. That cycle comes floor(H/2) × (`prescale` + 1) cycles after the first high cycle, where H = `high_count` + d. The first high cycle counts as offset 0.
- R7: When `start` is low at the last cycle of a high phase, the generator goes idle and `scl_out` stays high with no strobes. Dropping `start` earlier in a period never shortens that period.
- R8: Changes to `prescale`, `low_count` or `high_count` while a period is running have no effect on that period. They take effect from the next period onward.
- R9: Pulling `enable` low in the middle of a period ends it at once: in the next cycle `scl_out` is 1. A later restart begins with a complete low phase.
- R10: From idle, with `enable` high, a `start` sampled high at a clock edge drives `scl_out` low right after that edge. `scl_out` never falls unless `start` and `enable` were both high at the edge before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Run enable; low holds the generator cleared and idle |
| start | input | 1 | Request for clock periods, sampled at each period boundary |
| prescale | input | PSC_W | Prescaler setting; module clock is divided by prescale + 1 |
| low_count | input | CNT_W | Programmed low-phase count in prescaled ticks, before the extra delay |
| high_count | input | CNT_W | Programmed high-phase count in prescaled ticks, before the extra delay |
| scl_out | output | 1 | SCL drive: 0 pulls the line low, 1 releases it |
| sample_stb | output | 1 | One-cycle strobe in the middle of each high phase |
| change_stb | output | 1 | One-cycle strobe in the first cycle of each low phase |

## Verification
All outputs are registered, so each result appears one cycle after the edge that causes it. A `start` sampled from idle drops `scl_out` in the next cycle, and `change_stb` rises in that same cycle. A low `enable` releases `scl_out` one cycle after the edge that samples it. Phase edges come every L × (P + 1) and H × (P + 1) cycles. The sample strobe sits floor(H/2) × (P + 1) cycles into the high phase. The bench changes inputs only on falling edges and reads outputs on falling edges. It measures each phase by counting, from the first falling edge at which `scl_out` reads low, the cycles until the level changes. It compares these counts with values worked out from the requirement formulas. Register changes and stop requests are made one cycle after a period has started, so the running period must keep its old lengths.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } scl_phase_e;

    typedef struct packed {
        logic sample;
        logic change;
    } scl_strobe_t;

    // Extra ticks added to every phase, chosen by the prescaler setting.
    function automatic logic [2:0] extra_delay(input logic [31:0] psc);
        if (psc == 32'd0)
            return 3'd7;
        else if (psc == 32'd1)
            return 3'd6;
        else
            return 3'd5;
    endfunction

endpackage

// File: rtl/scl_cfg_shadow.sv
module scl_cfg_shadow #(
    parameter int PSC_W = 8,
    parameter int CNT_W = 16,
    localparam int LEN_W = CNT_W + 1
) (
    input  logic             clk,
    input  logic             clear,
    input  logic             load,
    input  logic [PSC_W-1:0] psc_in,
    input  logic [CNT_W-1:0] low_in,
    input  logic [CNT_W-1:0] high_in,
    output logic [PSC_W-1:0] psc_q,
    output logic [LEN_W-1:0] lo_len_q,
    output logic [LEN_W-1:0] hi_len_q,
    output logic [LEN_W-1:0] half_hi_q
);
    import scl_gen_pkg::*;

    logic [LEN_W-1:0] delay_ext;
    logic [LEN_W-1:0] lo_len_d;
    logic [LEN_W-1:0] hi_len_d;

    always_comb begin
        delay_ext = LEN_W'(extra_delay(32'(psc_in)));
        lo_len_d  = {1'b0, low_in}  + delay_ext;
        hi_len_d  = {1'b0, high_in} + delay_ext;
    end

    always_ff @(posedge clk) begin
        if (clear) begin
            psc_q     <= '0;
            lo_len_q  <= '0;
            hi_len_q  <= '0;
            half_hi_q <= '0;
        end else if (load) begin
            psc_q     <= psc_in;
            lo_len_q  <= lo_len_d;
            hi_len_q  <= hi_len_d;
            half_hi_q <= hi_len_d >> 1;
        end
    end

endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             clear,
    input  logic             run,
    input  logic [PSC_W-1:0] psc,
    output logic             tick
);
    logic [PSC_W-1:0] div_cnt;

    assign tick = run && (div_cnt == psc);

    always_ff @(posedge clk) begin
        if (clear || !run)
            div_cnt <= '0;
        else if (tick)
            div_cnt <= '0;
        else
            div_cnt <= div_cnt + PSC_W'(1);
    end

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm #(
    parameter int LEN_W = 17
) (
    input  logic                     clk,
    input  logic                     clear,
    input  logic                     start,
    input  logic                     tick,
    input  logic [LEN_W-1:0]         lo_len,
    input  logic [LEN_W-1:0]         hi_len,
    input  logic [LEN_W-1:0]         half_hi,
    output logic                     load,
    output logic                     run,
    output logic                     scl_q,
    output scl_gen_pkg::scl_strobe_t stb_q
);
    import scl_gen_pkg::*;

    scl_phase_e       state;
    logic [LEN_W-1:0] ph_cnt;
    logic [LEN_W-1:0] cur_len;
    logic             last_tick;
    logic             mid_tick;
    logic             boundary;

    always_comb begin
        cur_len   = (state == PH_HIGH) ? hi_len : lo_len;
        last_tick = tick && (ph_cnt == cur_len - LEN_W'(1));
        mid_tick  = tick && (state == PH_HIGH) && (ph_cnt == half_hi - LEN_W'(1));
        boundary  = (state == PH_IDLE) || ((state == PH_HIGH) && last_tick);
        load      = !clear && boundary && start;
        run       = (state != PH_IDLE);
    end

    always_ff @(posedge clk) begin
        if (clear) begin
            state  <= PH_IDLE;
            ph_cnt <= '0;
            scl_q  <= 1'b1;
            stb_q  <= '0;
        end else begin
            stb_q <= '0;
            unique case (state)
                PH_IDLE: begin
                    ph_cnt <= '0;
                    if (start) begin
                        state        <= PH_LOW;
                        scl_q        <= 1'b0;
                        stb_q.change <= 1'b1;
                    end
                end
                PH_LOW: begin
                    if (tick) begin
                        if (last_tick) begin
                            state  <= PH_HIGH;
                            scl_q  <= 1'b1;
                            ph_cnt <= '0;
                        end else begin
                            ph_cnt <= ph_cnt + LEN_W'(1);
                        end
                    end
                end
                PH_HIGH: begin
                    if (mid_tick)
                        stb_q.sample <= 1'b1;
                    if (tick) begin
                        if (last_tick) begin
                            ph_cnt <= '0;
                            if (start) begin
                                state        <= PH_LOW;
                                scl_q        <= 1'b0;
                                stb_q.change <= 1'b1;
                            end else begin
                                state <= PH_IDLE;
                            end
                        end else begin
                            ph_cnt <= ph_cnt + LEN_W'(1);
                        end
                    end
                end
                default: begin
                    state  <= PH_IDLE;
                    scl_q  <= 1'b1;
                    ph_cnt <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/scl_clock_gen.sv
module scl_clock_gen #(
    parameter int PSC_W = 8,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             start,
    input  logic [PSC_W-1:0] prescale,
    input  logic [CNT_W-1:0] low_count,
    input  logic [CNT_W-1:0] high_count,
    output logic             scl_out,
    output logic             sample_stb,
    output logic             change_stb
);
    import scl_gen_pkg::*;

    localparam int LEN_W = CNT_W + 1;

    logic             clear;
    logic             load;
    logic             run;
    logic             tick;
    logic [PSC_W-1:0] psc_q;
    logic [LEN_W-1:0] lo_len;
    logic [LEN_W-1:0] hi_len;
    logic [LEN_W-1:0] half_hi;
    scl_strobe_t      stb;

    assign clear = rst || !enable;

    scl_cfg_shadow #(.PSC_W(PSC_W), .CNT_W(CNT_W)) u_shadow (
        .clk       (clk),
        .clear     (clear),
        .load      (load),
        .psc_in    (prescale),
        .low_in    (low_count),
        .high_in   (high_count),
        .psc_q     (psc_q),
        .lo_len_q  (lo_len),
        .hi_len_q  (hi_len),
        .half_hi_q (half_hi)
    );

    scl_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk   (clk),
        .clear (clear),
        .run   (run),
        .psc   (psc_q),
        .tick  (tick)
    );

    scl_phase_fsm #(.LEN_W(LEN_W)) u_fsm (
        .clk     (clk),
        .clear   (clear),
        .start   (start),
        .tick    (tick),
        .lo_len  (lo_len),
        .hi_len  (hi_len),
        .half_hi (half_hi),
        .load    (load),
        .run     (run),
        .scl_q   (scl_out),
        .stb_q   (stb)
    );

    assign sample_stb = stb.sample;
    assign change_stb = stb.change;

endmodule

// File: rtl/scl_clock_gen_chk.sv
module scl_clock_gen_chk (
    input logic clk,
    input logic rst,
    input logic enable,
    input logic start,
    input logic scl_out,
    input logic sample_stb,
    input logic change_stb
);

    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (scl_out && !sample_stb && !change_stb)); // R1

    AST_CHANGE_AT_FALL: assert property (@(posedge clk) disable iff (rst)
        $fell(scl_out) |-> change_stb); // R5

    AST_CHANGE_WHILE_LOW: assert property (@(posedge clk) disable iff (rst)
        change_stb |-> !scl_out); // R5

    AST_CHANGE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        change_stb |=> !change_stb); // R5

    AST_SAMPLE_WHILE_HIGH: assert property (@(posedge clk) disable iff (rst)
        sample_stb |-> scl_out); // R6

    AST_SAMPLE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        sample_stb |=> !sample_stb); // R6

    AST_FALL_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
        $fell(scl_out) |-> $past(start && enable)); // R10

endmodule

bind scl_clock_gen scl_clock_gen_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .start      (start),
    .scl_out    (scl_out),
    .sample_stb (sample_stb),
    .change_stb (change_stb)
);

// File: tb/scl_clock_gen_test.sv
`timescale 1ns/1ps
module scl_clock_gen_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  prescale = '0;
    logic [15:0] low_count = '0;
    logic [15:0] high_count = '0;
    logic        scl_out;
    logic        sample_stb;
    logic        change_stb;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #5 clk = ~clk;

    scl_clock_gen uut (
        .clk        (clk),
        .rst        (rst),
        .enable     (enable),
        .start      (start),
        .prescale   (prescale),
        .low_count  (low_count),
        .high_count (high_count),
        .scl_out    (scl_out),
        .sample_stb (sample_stb),
        .change_stb (change_stb)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // R4: extra delay from the prescaler value
    function automatic int exp_d(input int p);
        if (p == 0) return 7;
        if (p == 1) return 6;
        return 5;
    endfunction

    // Called at the falling edge of the first low cycle of a period.
    task automatic measure(input int elo, input int ehi, input int esp,
                           input bit stop, input string tag);
        int lo = 0;
        int hi = 0;
        int sp = -1;
        int ns = 0;
        int nc = 0;
        int cap;
        cap = stop ? ehi + 40 : 1000000;
        chk(change_stb == 1'b1, {"R5 change strobe at low start ", tag}, change_stb, 1);
        while (scl_out == 1'b0 && lo < 100000) begin
            if (lo > 0 && change_stb) nc++;
            if (sample_stb) ns++;
            lo++;
            @(negedge clk);
        end
        while (scl_out == 1'b1 && hi < cap) begin
            if (sample_stb) begin
                if (sp < 0) sp = hi;
                ns++;
            end
            if (change_stb) nc++;
            hi++;
            @(negedge clk);
        end
        chk(lo == elo, {"R2 low length ", tag}, lo, elo);
        if (stop)
            chk(hi == cap, {"R7 stays released after stop ", tag}, hi, cap);
        else
            chk(hi == ehi, {"R3 high length ", tag}, hi, ehi);
        chk(sp == esp, {"R6 sample offset ", tag}, sp, esp);
        chk(ns == 1, {"R6 sample count ", tag}, ns, 1);
        chk(nc == 0, {"R5 no extra change strobe ", tag}, nc, 0);
    endtask

    task automatic set_cfg(input int p, input int l, input int h);
        prescale   = 8'(p);
        low_count  = 16'(l);
        high_count = 16'(h);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(scl_out == 1'b1, "R1 scl released in reset", scl_out, 1);
        chk(sample_stb == 1'b0 && change_stb == 1'b0, "R1 no strobes in reset",
            {sample_stb, change_stb}, 0);
        rst = 1'b0;
        start = 1'b1;
        set_cfg(0, 3, 4);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (scl_out != 1'b1 || sample_stb || change_stb) begin
                chk(1'b0, "R1 held idle while enable low", scl_out, 1);
                break;
            end
        end
        chk(scl_out == 1'b1, "R1 idle after enable low with start", scl_out, 1);
        start = 1'b0;
        enable = 1'b1;
        @(negedge clk);
    endtask

    // R2 R3 R4 R6 R7 R10
    task automatic t_case(input int p, input int l, input int h, input string tag);
        int lo_c;
        int hi_c;
        int d;
        d = exp_d(p);
        lo_c = (l + d) * (p + 1);
        hi_c = (h + d) * (p + 1);
        set_cfg(p, l, h);
        start = 1'b1;
        @(negedge clk);
        chk(scl_out == 1'b0, {"R10 falls one cycle after start ", tag}, scl_out, 0);
        measure(lo_c, hi_c, ((h + d) / 2) * (p + 1), 1'b0, {"R4 ", tag});
        start = 1'b0;
        measure(lo_c, hi_c, ((h + d) / 2) * (p + 1), 1'b1, {"R4 ", tag});
    endtask

    // R8: new values written during a running period wait for the next one
    task automatic t_update();
        set_cfg(0, 3, 4);
        start = 1'b1;
        @(negedge clk);
        set_cfg(1, 2, 5);
        measure(10, 11, 5, 1'b0, "R8 old values kept");
        start = 1'b0;
        measure(16, 22, 10, 1'b1, "R8 new values next period");
    endtask

    // R9: enable drop in mid period
    task automatic t_disable();
        set_cfg(0, 3, 4);
        start = 1'b1;
        @(negedge clk);
        repeat (3) @(negedge clk);
        chk(scl_out == 1'b0, "R9 still low before disable", scl_out, 0);
        enable = 1'b0;
        @(negedge clk);
        chk(scl_out == 1'b1, "R9 released one cycle after disable", scl_out, 1);
        chk(change_stb == 1'b0 && sample_stb == 1'b0, "R9 no strobes after disable",
            {sample_stb, change_stb}, 0);
        repeat (4) @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
        chk(scl_out == 1'b0, "R9 restart falls after enable", scl_out, 0);
        start = 1'b0;
        measure(10, 11, 5, 1'b1, "R9 full period after restart");
    endtask

    initial begin
        t_reset();
        t_case(0, 3, 4, "psc0");
        t_case(1, 2, 5, "psc1");
        t_case(2, 0, 0, "psc2");
        t_case(3, 4, 1, "psc3");
        t_update();
        t_disable();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule